// File: doc/BRIEF.md
# Per-tone frequency-domain LMS equalizer

This block corrects the gain and phase of every subchannel in a multitone receiver after the FFT. Each incoming complex sample carries the index of its tone. The block looks up that tone's single complex coefficient and returns the complex product as the equalized sample. It also reports the error between a reference constellation point and that output.

While adaptation is allowed, the block moves the coefficient toward the reference with an LMS rule. The step is a power of two, so the update term is made with an arithmetic right shift and needs no multiplier. The reference is either a known 4-QAM training point or, outside training, a sign decision on the output. Coefficients are held in a register file indexed by tone, with one read and one write-back per sample. The voice-band tones pass through untouched. A freeze control and a burst-window control decide when coefficients may change.

Top module: `feq_top`

## Requirements
- R1: For an active tone (index 7 to 256), the output is the complex product of the input sample and that tone's coefficient. Coefficients are signed 16-bit Q1.14. Each product component is (sum + 2^13) >>> 14, saturated to signed 16 bits. After reset every coefficient equals 1 + j0 (real 16384, imaginary 0).
- R2: A tone outside 7 to 256, including 0 to 6, leaves the block unchanged: output equals input, error is 0, and no coefficient changes.
- R3: An accepted sample appears on out_valid, out_tone, the output and the error after exactly two rising edges, one result per sample and in order. During and after reset, out_valid and all data outputs are 0.
- R4: When train_en is high, the reference is ±16384 ± j16384. train_sym bit 0 set makes the real part negative, and bit 1 set makes the imaginary part negative. The error is reference minus output, saturated to 16 bits per component.
- R5: When train_en is low, each reference component is -16384 if that output component is negative and +16384 otherwise (zero counts as positive).
- R6: With adaptation allowed, the coefficient becomes sat16(c + ((e·conj(x)) >>> (14 + k))). k is 1, 3, 5 or 7 for step_sel 0, 1, 2 or 3.
- R7: While freeze is high at capture, no coefficient changes, and outputs and errors are still produced.
- R8: While burst_mode is high, a sample adapts only if burst_win is high at its capture. Otherwise its coefficient is held.
- R9: A sample for the same tone captured right after another uses the coefficient already updated by that earlier sample.
- R10: The coefficient update saturates at +32767 / -32768 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_tone | input | 9 | Tone index of the sample |
| in_re | input | 16 | Sample real part |
| in_im | input | 16 | Sample imaginary part |
| train_en | input | 1 | Use the training symbol as reference |
| train_sym | input | 2 | Training point signs: bit 0 real negative, bit 1 imaginary negative |
| step_sel | input | 2 | Step exponent select (1, 3, 5, 7) |
| freeze | input | 1 | Hold all coefficients |
| burst_mode | input | 1 | Restrict adaptation to the burst window |
| burst_win | input | 1 | Burst window open |
| out_valid | output | 1 | Result present |
| out_tone | output | 9 | Tone index of the result |
| out_re | output | 16 | Equalized real part |
| out_im | output | 16 | Equalized imaginary part |
| err_re | output | 16 | Error real part |
| err_im | output | 16 | Error imaginary part |

## Verification
The hardest situations to reach are a saturated coefficient and a forwarded write-back. The ports cannot load a coefficient, so one can only be driven to its limit by training. The stimulus trains a tone with a small input and the largest step, which pushes the coefficient's ideal value well past the Q1.14 range. It then keeps feeding that tone back to back, so forwarding is exercised in the same run. Freeze and burst holds are shown through later outputs of the same tone, which must still reflect the earlier coefficient.

// File: rtl/feq_pkg.sv
// Shared widths, complex sample type and saturation helper for the
// frequency-domain equalizer. Assumes all arithmetic fits WIDE_W bits.
package feq_pkg;
    parameter int unsigned SMP_W  = 16;
    parameter int unsigned WIDE_W = 48;

    typedef logic signed [WIDE_W-1:0] wide_t;

    typedef struct packed {
        logic signed [SMP_W-1:0] re;
        logic signed [SMP_W-1:0] im;
    } cplx_t;

    // Clamp a wide signed value into the sample range.
    function automatic logic signed [SMP_W-1:0] sat_w(input wide_t v);
        wide_t hi;
        wide_t lo;
        hi = wide_t'((2 ** (SMP_W - 1)) - 1);
        lo = -wide_t'(2 ** (SMP_W - 1));
        if (v > hi)      return hi[SMP_W-1:0];
        else if (v < lo) return lo[SMP_W-1:0];
        else             return v[SMP_W-1:0];
    endfunction
endpackage

// File: rtl/feq_cmul.sv
// Complex multiply of a sample by a Q1.FRAC_W coefficient, with
// round-half-up and saturation. Purely combinational.
module feq_cmul
    import feq_pkg::*;
#(
    parameter int FRAC_W = 14
) (
    input  cplx_t a,
    input  cplx_t b,
    output cplx_t y
);
    localparam wide_t RND = wide_t'(1) <<< (FRAC_W - 1);

    wide_t pr, pi;

    // Form both product sums, round and clamp.
    always_comb begin
        pr   = wide_t'(a.re) * wide_t'(b.re) - wide_t'(a.im) * wide_t'(b.im);
        pi   = wide_t'(a.re) * wide_t'(b.im) + wide_t'(a.im) * wide_t'(b.re);
        y.re = sat_w((pr + RND) >>> FRAC_W);
        y.im = sat_w((pi + RND) >>> FRAC_W);
    end
endmodule

// File: rtl/feq_err.sv
// Picks the 4-QAM reference (training point or sign decision) and forms
// the saturated error. Error is zero for tones that are not equalized.
module feq_err
    import feq_pkg::*;
#(
    parameter int REF_MAG = 16384
) (
    input  cplx_t      y,
    input  logic       active,
    input  logic       train,
    input  logic [1:0] tsym,
    output cplx_t      e
);
    localparam wide_t RPOS = wide_t'(REF_MAG);

    wide_t ref_re, ref_im;

    // Reference selection and error subtraction.
    always_comb begin
        if (train) begin
            ref_re = tsym[0] ? -RPOS : RPOS;
            ref_im = tsym[1] ? -RPOS : RPOS;
        end else begin
            ref_re = y.re[SMP_W-1] ? -RPOS : RPOS;
            ref_im = y.im[SMP_W-1] ? -RPOS : RPOS;
        end
        if (active) begin
            e.re = sat_w(ref_re - wide_t'(y.re));
            e.im = sat_w(ref_im - wide_t'(y.im));
        end else begin
            e = '0;
        end
    end
endmodule

// File: rtl/feq_lms.sv
// Power-of-two LMS step: c + (e * conj(x)) >>> (FRAC_W + sh), saturated.
// The step is a shift only; sh is the step exponent.
module feq_lms
    import feq_pkg::*;
#(
    parameter int FRAC_W = 14,
    parameter int SH_W   = 3
) (
    input  cplx_t            c,
    input  cplx_t            e,
    input  cplx_t            x,
    input  logic [SH_W-1:0]  sh,
    output cplx_t            c_new
);
    wide_t gr, gi, dr, di;

    // Gradient, shift by the step exponent, clamped accumulate.
    always_comb begin
        gr = wide_t'(e.re) * wide_t'(x.re) + wide_t'(e.im) * wide_t'(x.im);
        gi = wide_t'(e.im) * wide_t'(x.re) - wide_t'(e.re) * wide_t'(x.im);
        dr = gr >>> (FRAC_W + int'(sh));
        di = gi >>> (FRAC_W + int'(sh));
        c_new.re = sat_w(wide_t'(c.re) + dr);
        c_new.im = sat_w(wide_t'(c.im) + di);
    end
endmodule

// File: rtl/feq_coef_rf.sv
// Tone-indexed coefficient register file: one registered read and one
// write per cycle, reset to 1+j0. An optional bypass hands a same-cycle
// write to the reader. Addresses at or beyond NUM read as 1+j0.
module feq_coef_rf
    import feq_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int NUM    = 257,
    parameter int FRAC_W = 14,
    parameter bit FWD_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  cplx_t             wr_data,
    output cplx_t             rd_data
);
    localparam cplx_t UNITY = '{re: SMP_W'(1 << FRAC_W), im: '0};

    cplx_t mem [NUM];
    cplx_t raw;
    cplx_t rd_next;

    // Storage with reset to unity and indexed write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM; i++) mem[i] <= UNITY;
        end else if (wr_en && (int'(wr_addr) < NUM)) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Range-guarded array lookup.
    always_comb raw = (int'(rd_addr) < NUM) ? mem[rd_addr] : UNITY;

    generate
        if (FWD_EN) begin : g_fwd
            // Take the word being written when it targets the read address.
            always_comb rd_next = (wr_en && wr_addr == rd_addr) ? wr_data : raw;
        end else begin : g_nofwd
            // Plain read of the stored word.
            always_comb rd_next = raw;
        end
    endgenerate

    // Read register.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= UNITY;
        else if (rd_en) rd_data <= rd_next;
    end
endmodule

// File: rtl/feq_top.sv
// Per-tone frequency-domain LMS equalizer, two pipeline stages.
// Stage 1 captures the sample and reads its coefficient. Stage 2
// multiplies, forms the error, writes the updated coefficient back and
// registers the outputs. Assumes tone indices within TONE_W bits.
module feq_top
    import feq_pkg::*;
#(
    parameter int TONE_W  = 9,
    parameter int TONE_LO = 7,
    parameter int TONE_HI = 256,
    parameter int FRAC_W  = 14,
    parameter int REF_MAG = 16384
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [TONE_W-1:0]       in_tone,
    input  logic signed [SMP_W-1:0] in_re,
    input  logic signed [SMP_W-1:0] in_im,
    input  logic                    train_en,
    input  logic [1:0]              train_sym,
    input  logic [1:0]              step_sel,
    input  logic                    freeze,
    input  logic                    burst_mode,
    input  logic                    burst_win,
    output logic                    out_valid,
    output logic [TONE_W-1:0]       out_tone,
    output logic signed [SMP_W-1:0] out_re,
    output logic signed [SMP_W-1:0] out_im,
    output logic signed [SMP_W-1:0] err_re,
    output logic signed [SMP_W-1:0] err_im
);
    localparam int NUM = TONE_HI + 1;
    localparam logic [TONE_W-1:0] LO_T = TONE_W'(TONE_LO);
    localparam logic [TONE_W-1:0] HI_T = TONE_W'(TONE_HI);

    logic              in_act, in_adapt;
    logic              s1_vld, s1_act, s1_adapt, s1_train;
    logic [TONE_W-1:0] s1_tone;
    logic [1:0]        s1_tsym;
    logic [2:0]        s1_sh;
    cplx_t             s1_x, s1_c;
    cplx_t             y_mul, y_sel, e_cur, c_upd;
    logic              rf_wr_en;

    // Classify the incoming tone and the adaptation permission.
    always_comb begin
        in_act   = (in_tone >= LO_T) && (in_tone <= HI_T);
        in_adapt = in_act && !freeze && (!burst_mode || burst_win);
    end

    // Stage 1 capture of sample and controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_act   <= 1'b0;
            s1_adapt <= 1'b0;
            s1_train <= 1'b0;
            s1_tone  <= '0;
            s1_tsym  <= '0;
            s1_sh    <= '0;
            s1_x     <= '0;
        end else begin
            s1_vld   <= in_valid;
            s1_act   <= in_act;
            s1_adapt <= in_adapt;
            s1_train <= train_en;
            s1_tone  <= in_tone;
            s1_tsym  <= train_sym;
            s1_sh    <= {step_sel, 1'b1};
            s1_x     <= '{re: in_re, im: in_im};
        end
    end

    feq_coef_rf #(
        .ADDR_W(TONE_W), .NUM(NUM), .FRAC_W(FRAC_W), .FWD_EN(1'b1)
    ) u_rf (
        .clk(clk), .rst_n(rst_n),
        .rd_en(in_valid), .rd_addr(in_tone),
        .wr_en(rf_wr_en), .wr_addr(s1_tone), .wr_data(c_upd),
        .rd_data(s1_c)
    );

    feq_cmul #(.FRAC_W(FRAC_W)) u_mul (.a(s1_x), .b(s1_c), .y(y_mul));

    // Bypass the product for tones outside the equalized band.
    always_comb y_sel = s1_act ? y_mul : s1_x;

    feq_err #(.REF_MAG(REF_MAG)) u_err (
        .y(y_sel), .active(s1_act), .train(s1_train), .tsym(s1_tsym), .e(e_cur)
    );

    feq_lms #(.FRAC_W(FRAC_W), .SH_W(3)) u_lms (
        .c(s1_c), .e(e_cur), .x(s1_x), .sh(s1_sh), .c_new(c_upd)
    );

    // Write-back strobe for an adapting sample in stage 2.
    always_comb rf_wr_en = s1_vld && s1_adapt;

    // Stage 2 output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tone  <= '0;
            out_re    <= '0;
            out_im    <= '0;
            err_re    <= '0;
            err_im    <= '0;
        end else begin
            out_valid <= s1_vld;
            out_tone  <= s1_tone;
            out_re    <= y_sel.re;
            out_im    <= y_sel.im;
            err_re    <= e_cur.re;
            err_im    <= e_cur.im;
        end
    end
endmodule

// File: rtl/feq_chk.sv
// Property checker for feq_top, attached by bind below.
module feq_chk
    import feq_pkg::*;
#(
    parameter int TONE_W  = 9,
    parameter int TONE_LO = 7,
    parameter int TONE_HI = 256
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [TONE_W-1:0]       in_tone,
    input logic signed [SMP_W-1:0] in_re,
    input logic signed [SMP_W-1:0] in_im,
    input logic                    freeze,
    input logic                    burst_mode,
    input logic                    burst_win,
    input logic                    out_valid,
    input logic [TONE_W-1:0]       out_tone,
    input logic signed [SMP_W-1:0] out_re,
    input logic signed [SMP_W-1:0] out_im,
    input logic signed [SMP_W-1:0] err_re,
    input logic signed [SMP_W-1:0] err_im,
    input logic                    wr_en
);
    localparam logic [TONE_W-1:0] LO_T = TONE_W'(TONE_LO);
    localparam logic [TONE_W-1:0] HI_T = TONE_W'(TONE_HI);

    logic [1:0] age;
    logic       out_act, in_act_c;

    // Count cycles since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)        age <= '0;
        else if (age != 2) age <= age + 2'd1;
    end

    // Band classification at the two ends.
    always_comb begin
        out_act  = (out_tone >= LO_T) && (out_tone <= HI_T);
        in_act_c = (in_tone >= LO_T) && (in_tone <= HI_T);
    end

    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2) |-> (out_valid == $past(in_valid, 2)));

    a_r3_tone_order: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2 && out_valid) |-> (out_tone == $past(in_tone, 2)));

    a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2 && out_valid && !out_act) |->
        (out_re == $past(in_re, 2) && out_im == $past(in_im, 2) &&
         err_re == '0 && err_im == '0));

    a_r2_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 0 && wr_en) |-> $past(in_act_c));

    a_r7_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 0 && wr_en) |-> !$past(freeze));

    a_r8_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 0 && wr_en && $past(burst_mode)) |-> $past(burst_win));
endmodule

bind feq_top feq_chk #(
    .TONE_W(TONE_W), .TONE_LO(TONE_LO), .TONE_HI(TONE_HI)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tone(in_tone),
    .in_re(in_re), .in_im(in_im), .freeze(freeze), .burst_mode(burst_mode),
    .burst_win(burst_win), .out_valid(out_valid), .out_tone(out_tone),
    .out_re(out_re), .out_im(out_im), .err_re(err_re), .err_im(err_im),
    .wr_en(rf_wr_en)
);

// File: tb/tb_feq_top.sv
// Scoreboard bench: the driver computes expected results from a bench
// model of the requirements and queues them; the monitor compares.
module tb_feq_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [8:0]        in_tone = '0;
    logic signed [15:0] in_re = '0, in_im = '0;
    logic              train_en = 1'b0;
    logic [1:0]        train_sym = '0, step_sel = '0;
    logic              freeze = 1'b0, burst_mode = 1'b0, burst_win = 1'b0;
    logic              out_valid;
    logic [8:0]        out_tone;
    logic signed [15:0] out_re, out_im, err_re, err_im;

    feq_top dut (.*);

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0, bad = 0;
    bit done = 0;

    typedef struct { int tone; int yr; int yi; int er; int ei; int cyc; int req; } exp_t;
    exp_t q[$];

    longint mcr[0:256];
    longint mci[0:256];

    // Bench configuration copied to the inputs with each sample.
    int cfg_step = 0;
    bit cfg_frz = 0, cfg_bm = 0, cfg_bw = 0;

    function automatic longint s16(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic chk(input int req, input string what, input longint act, input longint expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Drive one sample at a falling edge and queue its expected result.
    task automatic drive(input int tone, input int xr, input int xi,
                         input bit tr, input int ts, input int req);
        exp_t it;
        longint yr, yi, rr, ri, er, ei, cr, ci;
        int k;
        bit act, adapt;
        @(negedge clk);
        in_valid = 1; in_tone = 9'(tone); in_re = 16'(xr); in_im = 16'(xi);
        train_en = tr; train_sym = 2'(ts); step_sel = 2'(cfg_step);
        freeze = cfg_frz; burst_mode = cfg_bm; burst_win = cfg_bw;
        act = (tone >= 7 && tone <= 256);
        adapt = act && !cfg_frz && (!cfg_bm || cfg_bw);
        if (act) begin
            cr = mcr[tone]; ci = mci[tone];
            yr = s16((xr * cr - xi * ci + 8192) >>> 14);
            yi = s16((xr * ci + xi * cr + 8192) >>> 14);
            if (tr) begin
                rr = ts[0] ? -16384 : 16384;
                ri = ts[1] ? -16384 : 16384;
            end else begin
                rr = (yr < 0) ? -16384 : 16384;
                ri = (yi < 0) ? -16384 : 16384;
            end
            er = s16(rr - yr); ei = s16(ri - yi);
            if (adapt) begin
                k = 2 * cfg_step + 1;
                mcr[tone] = s16(cr + ((er * xr + ei * xi) >>> (14 + k)));
                mci[tone] = s16(ci + ((ei * xr - er * xi) >>> (14 + k)));
            end
        end else begin
            yr = xr; yi = xi; er = 0; ei = 0;
        end
        it.tone = tone; it.yr = int'(yr); it.yi = int'(yi);
        it.er = int'(er); it.ei = int'(ei); it.cyc = cyc + 2; it.req = req;
        q.push_back(it);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 0;
        end
    endtask

    // Monitor: pop and compare every result the design produces.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                chk(3, "unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(3, "result cycle", cyc, e.cyc);
                chk(3, "out_tone", out_tone, e.tone);
                chk(e.req, "out_re", out_re, e.yr);
                chk(e.req, "out_im", out_im, e.yi);
                chk(e.req, "err_re", err_re, e.er);
                chk(e.req, "err_im", err_im, e.ei);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL R3 watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t <= 256; t++) begin mcr[t] = 16384; mci[t] = 0; end
        repeat (3) @(negedge clk);
        // R3: reset state
        chk(3, "reset out_valid", out_valid, 0);
        chk(3, "reset out_re", out_re, 0);
        chk(3, "reset err_im", err_im, 0);
        rst_n = 1;
        idle(2);
        chk(3, "idle out_valid", out_valid, 0);

        // R1: unity coefficient after reset, frozen so nothing moves
        cfg_frz = 1;
        drive(10, 1000, -2000, 0, 0, 1);
        drive(256, -32768, 32767, 0, 0, 1);
        drive(7, 12345, 321, 0, 0, 1);
        cfg_frz = 0;

        // R2: out-of-band tones pass unchanged, adaptation settings on
        for (int t = 0; t <= 6; t++) drive(t, 3000 + t, -500 * t, 1, 3, 2);
        drive(257, -7, 9, 1, 0, 2);
        drive(511, 32767, -32768, 0, 0, 2);

        // R4: training on tone 20 with the largest step
        cfg_step = 0;
        for (int i = 0; i < 8; i++) drive(20, 8192, 4096, 1, i % 4, 4);
        idle(1);
        // R5: decision-directed afterwards
        drive(20, 8000, -3000, 0, 0, 5);
        drive(20, -9000, 5000, 0, 0, 5);
        drive(21, 0, 0, 0, 0, 5);

        // R6: each step exponent on its own tone
        for (int s = 0; s < 4; s++) begin
            cfg_step = s;
            for (int i = 0; i < 4; i++) drive(30 + s, 6000, -2000, 1, 1, 6);
        end
        cfg_step = 0;

        // R7: freeze holds coefficients while outputs continue
        cfg_frz = 1;
        for (int i = 0; i < 5; i++) drive(40, 5000, 1000, 1, 2, 7);
        cfg_frz = 0;
        idle(2);
        drive(40, 5000, 1000, 1, 2, 7);
        drive(40, 5000, 1000, 1, 2, 7);

        // R8: burst window gating
        cfg_bm = 1;
        for (int i = 0; i < 8; i++) begin
            cfg_bw = (i % 3 == 0);
            drive(45, 7000, -7000, 1, 0, 8);
        end
        cfg_bm = 0; cfg_bw = 0;

        // R9: back-to-back samples on one tone, then interleaved tones
        for (int i = 0; i < 6; i++) drive(50, 10000, 2000, 1, 3, 9);
        for (int i = 0; i < 6; i++) drive((i % 2) ? 51 : 52, 9000, -4000, 1, 0, 9);

        // R10: small input and largest step drive the coefficient to its limit
        for (int i = 0; i < 40; i++) drive(60, 4096, 0, 1, 0, 10);
        for (int i = 0; i < 30; i++) drive(61, -4096, 0, 1, 2, 10);
        drive(60, 4096, 0, 1, 0, 10);

        idle(6);
        // R3: one result per sample
        chk(3, "queue drained", q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule